// File: doc/BRIEF.md
# Receive Packet Statistics Increment Generator

This block sits beside an Ethernet receive MAC and turns its per-packet summary into one-cycle increment values for a bank of external statistics counters. Each finished packet is reported by an end-of-packet strobe. The strobe comes with the packet length in bytes, a frame check sequence (FCS) error flag and a general error flag. A separate input carries the number of raw bytes seen in each cycle. The counters, any register readout, framing and FCS computation all live outside this block.

From these inputs the block produces:
- total-byte and total-packet increments;
- good-byte and good-packet increments;
- a bad-FCS increment;
- a one-hot group of length-histogram pulses.

The histogram bins are not powers of two. They sit around the standard and VLAN-tagged maximum frame sizes. The good-byte value stays zero until a packet closes with no error, and in that cycle it carries the whole packet length. Every output is registered and everything runs in the receive clock domain.

Top module: `rx_stat_incr`

## Requirements
- R1: `tot_bytes_inc` equals the `raw_bytes` value from the previous cycle, in every cycle out of reset.
- R2: `tot_pkts_inc` is 1 in the cycle after each `eop_valid` and 0 otherwise, whatever the length or the flags.
- R3: `good_pkt_inc` is 1 exactly one cycle after an `eop_valid` where both `eop_fcs_err` and `eop_err` are 0.
- R4: `good_bytes_inc` carries the full `eop_len` one cycle after a good packet (as in R3) and is 0 in every other cycle.
- R5: `bad_fcs_inc` is 1 one cycle after an `eop_valid` with `eop_fcs_err` set and 64 <= `eop_len` <= `max_pkt_len`, both bounds included. `max_pkt_len` is the value sampled at the strobe.
- R6: one cycle after `eop_valid`, `hist_inc` raises the bit of the bin that holds `eop_len`, for good and bad packets alike. The bit positions are:
  - bit 0 = 64;
  - bit 1 = 65..127;
  - bit 2 = 128..255;
  - bit 3 = 256..511;
  - bit 4 = 512..1023;
  - bit 5 = 1024..1518;
  - bit 6 = 1519..1522;
  - bit 7 = 1523..1548;
  - bit 8 = 1549..2047;
  - bit 9 = 2048..4095;
  - bit 10 = 4096..8191.
- R7: a packet shorter than 64 bytes or longer than 8191 bytes raises no `hist_inc` bit but still gives `tot_pkts_inc` = 1.
- R8: at most one `hist_inc` bit is set in any cycle, and none is set in a cycle that follows a cycle without `eop_valid`.
- R9: a synchronous active-high `rst` drives every output to zero on the next clock edge.
- R10: strobes on consecutive cycles each produce their own increments on consecutive cycles, with no lost or merged pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_bytes | input | 8 | Bytes received in this cycle |
| eop_valid | input | 1 | End-of-packet strobe |
| eop_len | input | 14 | Packet length in bytes, valid with the strobe |
| eop_fcs_err | input | 1 | FCS error flag of the packet |
| eop_err | input | 1 | Any other error flag of the packet |
| max_pkt_len | input | 15 | Upper length limit for bad-FCS counting |
| tot_bytes_inc | output | 8 | Total byte increment |
| tot_pkts_inc | output | 4 | Total packet increment |
| good_bytes_inc | output | 14 | Good byte increment |
| good_pkt_inc | output | 1 | Good packet increment |
| bad_fcs_inc | output | 1 | Bad-FCS increment |
| hist_inc | output | 11 | Length-histogram increment pulses |

## Verification
The main table drives one packet at each lower and upper edge of every histogram bin, with the flags varied per row. This shows whether a comparison is off by one, and whether the histogram ignores the error flags while the good outputs do not. Further rows place FCS-errored packets just below 64 bytes, exactly at the length limit and one byte above it, to pin down the inclusive window for bad-FCS counting. Lengths of 63, 8192 and the largest encodable value prove that packets outside the histogram range still count. Directed sequences send strobes back to back, leave gaps in which only the raw byte count moves, and assert reset in the middle of traffic.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

    localparam int NUM_BINS = 11;

    // Inclusive lower edge of each histogram bin; bit order is part of the contract.
    function automatic logic [31:0] bin_lo(input int idx);
        case (idx)
            0:       bin_lo = 32'd64;
            1:       bin_lo = 32'd65;
            2:       bin_lo = 32'd128;
            3:       bin_lo = 32'd256;
            4:       bin_lo = 32'd512;
            5:       bin_lo = 32'd1024;
            6:       bin_lo = 32'd1519;
            7:       bin_lo = 32'd1523;
            8:       bin_lo = 32'd1549;
            9:       bin_lo = 32'd2048;
            default: bin_lo = 32'd4096;
        endcase
    endfunction

    // Inclusive upper edge: one below the next bin's lower edge, last bin ends at 8191.
    function automatic logic [31:0] bin_hi(input int idx);
        if (idx >= NUM_BINS - 1)
            bin_hi = 32'd8191;
        else
            bin_hi = bin_lo(idx + 1) - 32'd1;
    endfunction

endpackage

// File: rtl/rx_stat_binner.sv
module rx_stat_binner
    import rx_stat_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             strobe,
    input  logic [LEN_W-1:0] len,
    output logic [NUM_BINS-1:0] hit
);
    localparam int PAD_W = 32 - LEN_W;

    logic [31:0] len_wide;
    assign len_wide = {{PAD_W{1'b0}}, len};

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
        assign hit[g] = strobe && (len_wide >= bin_lo(g)) && (len_wide <= bin_hi(g));
    end
endmodule

// File: rtl/rx_stat_qualify.sv
module rx_stat_qualify #(
    parameter int LEN_W   = 14,
    parameter int MAXL_W  = 15,
    parameter int MIN_LEN = 64
) (
    input  logic              strobe,
    input  logic [LEN_W-1:0]  len,
    input  logic              fcs_bad,
    input  logic              other_bad,
    input  logic [MAXL_W-1:0] limit,
    output logic              is_good,
    output logic              is_fcs_cnt
);
    localparam int CMP_W = 32;

    logic [CMP_W-1:0] len_wide;
    logic [CMP_W-1:0] lim_wide;
    logic             in_window;

    assign len_wide  = {{(CMP_W-LEN_W){1'b0}}, len};
    assign lim_wide  = {{(CMP_W-MAXL_W){1'b0}}, limit};
    assign in_window = (len_wide >= CMP_W'(MIN_LEN)) && (len_wide <= lim_wide);

    assign is_good    = strobe && !fcs_bad && !other_bad;
    assign is_fcs_cnt = strobe && fcs_bad && in_window;
endmodule

// File: rtl/rx_stat_incr.sv
module rx_stat_incr
    import rx_stat_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int MAXL_W  = 15,
    parameter int TOTB_W  = 8,
    parameter int TOTP_W  = 4,
    parameter int MIN_LEN = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TOTB_W-1:0]    raw_bytes,
    input  logic                 eop_valid,
    input  logic [LEN_W-1:0]     eop_len,
    input  logic                 eop_fcs_err,
    input  logic                 eop_err,
    input  logic [MAXL_W-1:0]    max_pkt_len,
    output logic [TOTB_W-1:0]    tot_bytes_inc,
    output logic [TOTP_W-1:0]    tot_pkts_inc,
    output logic [LEN_W-1:0]     good_bytes_inc,
    output logic                 good_pkt_inc,
    output logic                 bad_fcs_inc,
    output logic [NUM_BINS-1:0]  hist_inc
);
    typedef struct packed {
        logic [TOTB_W-1:0]   tot_bytes;
        logic [TOTP_W-1:0]   tot_pkts;
        logic [LEN_W-1:0]    good_bytes;
        logic                good_pkt;
        logic                bad_fcs;
        logic [NUM_BINS-1:0] hist;
    } incr_t;

    incr_t st_d, st_q;

    logic                pkt_good;
    logic                pkt_fcs;
    logic [NUM_BINS-1:0] bin_hit;

    rx_stat_qualify #(
        .LEN_W  (LEN_W),
        .MAXL_W (MAXL_W),
        .MIN_LEN(MIN_LEN)
    ) u_qual (
        .strobe    (eop_valid),
        .len       (eop_len),
        .fcs_bad   (eop_fcs_err),
        .other_bad (eop_err),
        .limit     (max_pkt_len),
        .is_good   (pkt_good),
        .is_fcs_cnt(pkt_fcs)
    );

    rx_stat_binner #(
        .LEN_W(LEN_W)
    ) u_bin (
        .strobe(eop_valid),
        .len   (eop_len),
        .hit   (bin_hit)
    );

    always_comb begin
        st_d            = '0;
        st_d.tot_bytes  = raw_bytes;
        st_d.tot_pkts   = TOTP_W'(eop_valid);
        st_d.good_pkt   = pkt_good;
        st_d.good_bytes = pkt_good ? eop_len : '0;
        st_d.bad_fcs    = pkt_fcs;
        st_d.hist       = bin_hit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tot_bytes_inc  = st_q.tot_bytes;
    assign tot_pkts_inc   = st_q.tot_pkts;
    assign good_bytes_inc = st_q.good_bytes;
    assign good_pkt_inc   = st_q.good_pkt;
    assign bad_fcs_inc    = st_q.bad_fcs;
    assign hist_inc       = st_q.hist;
endmodule

// File: rtl/rx_stat_incr_chk.sv
module rx_stat_incr_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  raw_bytes,
    input logic        eop_valid,
    input logic [13:0] eop_len,
    input logic        eop_fcs_err,
    input logic        eop_err,
    input logic [14:0] max_pkt_len,
    input logic [7:0]  tot_bytes_inc,
    input logic [3:0]  tot_pkts_inc,
    input logic [13:0] good_bytes_inc,
    input logic        good_pkt_inc,
    input logic        bad_fcs_inc,
    input logic [10:0] hist_inc
);
    assert_tot_bytes_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tot_bytes_inc == $past(raw_bytes));

    assert_tot_pkts_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> tot_pkts_inc == {3'b000, $past(eop_valid)});

    assert_good_pkt_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> good_pkt_inc == $past(eop_valid && !eop_fcs_err && !eop_err));

    assert_good_bytes_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !(eop_valid && !eop_fcs_err && !eop_err) |=> good_bytes_inc == '0);

    assert_bad_fcs_cause_R5: assert property (@(posedge clk) disable iff (rst)
        !(eop_valid && eop_fcs_err) |=> !bad_fcs_inc);

    assert_hist_out_of_range_R7: assert property (@(posedge clk) disable iff (rst)
        (eop_valid && (eop_len < 14'd64 || eop_len > 14'd8191)) |=> hist_inc == '0);

    assert_hist_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hist_inc));

    assert_hist_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !eop_valid |=> hist_inc == '0);

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (tot_bytes_inc == '0 && tot_pkts_inc == '0 && good_bytes_inc == '0
                 && !good_pkt_inc && !bad_fcs_inc && hist_inc == '0));
endmodule

bind rx_stat_incr rx_stat_incr_chk u_chk (.*);

// File: tb/sim_rx_stat_incr.sv
module sim_rx_stat_incr;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  raw_bytes;
    logic        eop_valid;
    logic [13:0] eop_len;
    logic        eop_fcs_err;
    logic        eop_err;
    logic [14:0] max_pkt_len;
    logic [7:0]  tot_bytes_inc;
    logic [3:0]  tot_pkts_inc;
    logic [13:0] good_bytes_inc;
    logic        good_pkt_inc;
    logic        bad_fcs_inc;
    logic [10:0] hist_inc;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rx_stat_incr u0 (.*);

    typedef struct packed {
        logic [13:0] len;
        logic        fcs;
        logic        err;
        logic [14:0] maxl;
        logic [7:0]  bytes;
        logic [10:0] hist;
        logic        good;
        logic        bfcs;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{14'd64,    1'b0, 1'b0, 15'd1518,  8'd40,  11'h001, 1'b1, 1'b0},
        '{14'd63,    1'b0, 1'b0, 15'd1518,  8'd41,  11'h000, 1'b1, 1'b0},
        '{14'd65,    1'b1, 1'b0, 15'd1518,  8'd42,  11'h002, 1'b0, 1'b1},
        '{14'd127,   1'b0, 1'b1, 15'd1518,  8'd43,  11'h002, 1'b0, 1'b0},
        '{14'd128,   1'b0, 1'b0, 15'd1518,  8'd44,  11'h004, 1'b1, 1'b0},
        '{14'd255,   1'b0, 1'b0, 15'd1518,  8'd45,  11'h004, 1'b1, 1'b0},
        '{14'd511,   1'b1, 1'b0, 15'd1518,  8'd46,  11'h008, 1'b0, 1'b1},
        '{14'd512,   1'b0, 1'b0, 15'd1518,  8'd47,  11'h010, 1'b1, 1'b0},
        '{14'd1023,  1'b0, 1'b0, 15'd1518,  8'd48,  11'h010, 1'b1, 1'b0},
        '{14'd1024,  1'b0, 1'b0, 15'd1518,  8'd49,  11'h020, 1'b1, 1'b0},
        '{14'd1518,  1'b1, 1'b0, 15'd1518,  8'd50,  11'h020, 1'b0, 1'b1},
        '{14'd1519,  1'b1, 1'b0, 15'd1518,  8'd51,  11'h040, 1'b0, 1'b0},
        '{14'd1522,  1'b0, 1'b0, 15'd1518,  8'd52,  11'h040, 1'b1, 1'b0},
        '{14'd1523,  1'b0, 1'b0, 15'd1518,  8'd53,  11'h080, 1'b1, 1'b0},
        '{14'd1548,  1'b0, 1'b1, 15'd1518,  8'd54,  11'h080, 1'b0, 1'b0},
        '{14'd1549,  1'b0, 1'b0, 15'd1518,  8'd55,  11'h100, 1'b1, 1'b0},
        '{14'd2047,  1'b1, 1'b0, 15'd9000,  8'd56,  11'h100, 1'b0, 1'b1},
        '{14'd2048,  1'b0, 1'b0, 15'd9000,  8'd57,  11'h200, 1'b1, 1'b0},
        '{14'd4095,  1'b0, 1'b0, 15'd9000,  8'd58,  11'h200, 1'b1, 1'b0},
        '{14'd4096,  1'b0, 1'b0, 15'd9000,  8'd59,  11'h400, 1'b1, 1'b0},
        '{14'd8191,  1'b1, 1'b1, 15'd9600,  8'd60,  11'h400, 1'b0, 1'b1},
        '{14'd8192,  1'b0, 1'b0, 15'd9600,  8'd61,  11'h000, 1'b1, 1'b0},
        '{14'd63,    1'b1, 1'b0, 15'd1518,  8'd62,  11'h000, 1'b0, 1'b0},
        '{14'd16383, 1'b1, 1'b0, 15'd32767, 8'd255, 11'h000, 1'b0, 1'b1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [13:0] l, input logic f, input logic e,
                         input logic [14:0] m, input logic [7:0] b);
        eop_valid   = v;
        eop_len     = l;
        eop_fcs_err = f;
        eop_err     = e;
        max_pkt_len = m;
        raw_bytes   = b;
    endtask

    task automatic check_vec(input vec_t v);
        check("R1", "tot_bytes", int'(tot_bytes_inc), int'(v.bytes));
        check(v.hist == '0 ? "R7" : "R2", "tot_pkts", int'(tot_pkts_inc), 1);
        check("R3", "good_pkt", int'(good_pkt_inc), int'(v.good));
        check("R4", "good_bytes", int'(good_bytes_inc), v.good ? int'(v.len) : 0);
        check("R5", "bad_fcs", int'(bad_fcs_inc), int'(v.bfcs));
        check(v.hist == '0 ? "R7" : "R6", "hist", int'(hist_inc), int'(v.hist));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b1, 14'd100, 1'b1, 1'b0, 15'd1518, 8'd9);
        repeat (3) @(negedge clk);
        // R9: outputs held at zero under reset despite active inputs
        check("R9", "reset tot_bytes", int'(tot_bytes_inc), 0);
        check("R9", "reset tot_pkts", int'(tot_pkts_inc), 0);
        check("R9", "reset bad_fcs", int'(bad_fcs_inc), 0);
        check("R9", "reset hist", int'(hist_inc), 0);
        rst = 1'b0;
        drive(1'b0, 14'd0, 1'b0, 1'b0, 15'd1518, 8'd0);
        @(negedge clk);

        // Table walk: each vector strobed, checked one cycle later
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].len, VECS[i].fcs, VECS[i].err, VECS[i].maxl, VECS[i].bytes);
            @(negedge clk);
            check_vec(VECS[i]);
        end

        // Idle cycle: only raw byte count moves (R1, R8)
        drive(1'b0, 14'd200, 1'b1, 1'b0, 15'd1518, 8'd17);
        @(negedge clk);
        check("R1", "idle tot_bytes", int'(tot_bytes_inc), 17);
        check("R2", "idle tot_pkts", int'(tot_pkts_inc), 0);
        check("R8", "idle hist", int'(hist_inc), 0);
        check("R5", "idle bad_fcs", int'(bad_fcs_inc), 0);
        check("R4", "idle good_bytes", int'(good_bytes_inc), 0);

        // R10: back-to-back strobes, good then bad-FCS then good
        drive(1'b1, 14'd300, 1'b0, 1'b0, 15'd1518, 8'd1);
        @(negedge clk);
        check("R10", "b2b#1 good_bytes", int'(good_bytes_inc), 300);
        check("R10", "b2b#1 hist", int'(hist_inc), 11'h008);
        drive(1'b1, 14'd70, 1'b1, 1'b0, 15'd1518, 8'd2);
        @(negedge clk);
        check("R10", "b2b#2 good_bytes", int'(good_bytes_inc), 0);
        check("R10", "b2b#2 bad_fcs", int'(bad_fcs_inc), 1);
        check("R10", "b2b#2 hist", int'(hist_inc), 11'h002);
        drive(1'b1, 14'd70, 1'b0, 1'b0, 15'd1518, 8'd3);
        @(negedge clk);
        check("R10", "b2b#3 good_pkt", int'(good_pkt_inc), 1);
        check("R10", "b2b#3 bad_fcs", int'(bad_fcs_inc), 0);
        check("R10", "b2b#3 tot_pkts", int'(tot_pkts_inc), 1);

        // R5: limit below 64 excludes every length
        drive(1'b1, 14'd64, 1'b1, 1'b0, 15'd63, 8'd4);
        @(negedge clk);
        check("R5", "limit<64 bad_fcs", int'(bad_fcs_inc), 0);
        check("R6", "limit<64 hist", int'(hist_inc), 11'h001);

        // R9: reset in the middle of traffic
        drive(1'b1, 14'd1500, 1'b0, 1'b0, 15'd1518, 8'd77);
        rst = 1'b1;
        @(negedge clk);
        check("R9", "mid reset tot_bytes", int'(tot_bytes_inc), 0);
        check("R9", "mid reset good_bytes", int'(good_bytes_inc), 0);
        check("R9", "mid reset good_pkt", int'(good_pkt_inc), 0);
        check("R9", "mid reset hist", int'(hist_inc), 0);
        rst = 1'b0;
        drive(1'b0, 14'd0, 1'b0, 1'b0, 15'd1518, 8'd0);
        @(negedge clk);
        check("R2", "post reset tot_pkts", int'(tot_pkts_inc), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule